// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block is the landing zone for inbound message-signalled interrupts. A device's interrupt message arrives as a single write on a simple memory-mapped write port. The write address names a termination group and an index register inside that group. The low bits of the write data name one of the 16 vector bits in that register. The block sets that bit and holds it as pending.

The block has 16 groups. Each group has 8 index registers of 16 bits, which gives 2048 vectors in all. Each group also has a summary register that shows which of its index registers hold anything. Each group drives one level interrupt line. Software reads the summary register to find the busy index registers, then reads each of them. An index read returns the pending bits and clears them in the same access. A write that lands in the same cycle as a clear is not lost.

Top module: `msi_term_bank`

## Requirements
- R1: A write to window offset (g << 19) + (x << 16), with data d in 0..15, sets bit d of index register x of group g. Bits already set in that register stay set.
- R2: A read of window offset 0x800000 + (g << 16) returns group g's summary in rd_data[7:0], zero-extended. Bit x is 1 exactly when index register x of group g has any bit set.
- R3: A read of an index register returns its current contents in rd_data[15:0], zero-extended, and clears the register to zero. A second read returns zero.
- R4: A write and an index read may target the same register in the same cycle. The read returns the contents from before the write. The bit written in that cycle stays pending after the clear.
- R5: A write whose data is above 15 (any bit of wr_data[31:4] set) changes no state.
- R6: Some write addresses change no state: a nonzero offset in bits [15:0], bit 23 set, or any address in the summary region.
- R7: irq[g] is high exactly while some index register of group g holds a set bit. It rises on the clock edge after the write that sets the first bit.
- R8: A summary read, or a read of an address that is not a register, returns its value with no side effect. Reads of such addresses return zero.
- R9: An active-low asynchronous reset clears every pending bit, all irq outputs and rd_valid.
- R10: rd_valid and rd_data appear on the clock edge after rd_en. rd_valid is low in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Inbound interrupt write strobe |
| wr_addr | input | 24 | Write window offset |
| wr_data | input | 32 | Write data; the low 4 bits select the vector bit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 24 | Read window offset |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| irq | output | 16 | Per-group level interrupt |

## Verification
The properties assume that the bench changes wr_en, rd_en and reset only between clock edges. They also assume that any change to irq between two edges comes from a write or a clearing read seen at that edge. The bench drives every input on the falling edge and samples on the next falling edge, so each operation's effect is visible exactly one edge later.

The bench sweeps every group, index and bit position. Each read in the sweep targets a register whose contents the bench knows. This keeps the idle-stability properties meaningful when irq is compared against the expected value, which is computed arithmetically.

// File: rtl/msi_term_bank.sv
module msi_term_bank #(
  parameter int GROUPS = 16,
  parameter int IDXS   = 8,
  parameter int BITS   = 16,
  parameter int DW     = 32,
  localparam int GW    = $clog2(GROUPS),
  localparam int IW    = $clog2(IDXS),
  localparam int BW    = $clog2(BITS),
  localparam int SW    = GW + IW,
  localparam int AW    = 16 + SW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [GROUPS-1:0] irq
);

  logic [BITS-1:0] pend [GROUPS*IDXS];
  logic [IDXS-1:0] summ [GROUPS];

  wire wr_ok = wr_en && !wr_addr[AW-1] && (wr_addr[15:0] == '0)
               && (wr_data[DW-1:BW] == '0);
  wire [SW-1:0]   wr_slot = wr_addr[16 +: SW];
  wire [BITS-1:0] wr_mask = BITS'(1) << wr_data[BW-1:0];

  wire rd_idx = rd_en && !rd_addr[AW-1] && (rd_addr[15:0] == '0);
  wire rd_sum = rd_en && rd_addr[AW-1] && (rd_addr[AW-2:16+GW] == '0)
                && (rd_addr[15:0] == '0);
  wire [SW-1:0] rd_slot = rd_addr[16 +: SW];
  wire [GW-1:0] rd_grp  = rd_addr[16 +: GW];

  for (genvar e = 0; e < GROUPS*IDXS; e++) begin : g_ent
    wire hit_w = wr_ok  && (wr_slot == SW'(e));
    wire hit_r = rd_idx && (rd_slot == SW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend[e] <= '0;
      else if (hit_w || hit_r)
        pend[e] <= (hit_r ? '0 : pend[e]) | (hit_w ? wr_mask : '0);
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar x = 0; x < IDXS; x++) begin : g_idx
      assign summ[g][x] = |pend[g*IDXS + x];
    end
    assign irq[g] = |summ[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_idx)      rd_data <= DW'(pend[rd_slot]);
      else if (rd_sum) rd_data <= DW'(summ[rd_grp]);
      else             rd_data <= '0;
    end
  end

endmodule

module msi_term_bank_chk #(
  parameter int GROUPS = 16,
  parameter int IDXS   = 8,
  parameter int BITS   = 16,
  parameter int DW     = 32,
  localparam int GW    = $clog2(GROUPS),
  localparam int IW    = $clog2(IDXS),
  localparam int BW    = $clog2(BITS),
  localparam int AW    = 16 + GW + IW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              rd_en,
  input logic [AW-1:0]     rd_addr,
  input logic              rd_valid,
  input logic [DW-1:0]     rd_data,
  input logic [GROUPS-1:0] irq
);
  wire good_wr  = wr_en && !wr_addr[AW-1] && (wr_addr[15:0] == '0)
                  && (wr_data[DW-1:BW] == '0);
  wire [GW-1:0] wgrp = wr_addr[16+IW +: GW];
  wire sum_rd   = rd_addr[AW-1];
  wire bad_data = wr_data[DW-1:BW] != '0;

  p_write_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> irq[$past(wgrp)]);
  p_quiet_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (!rd_en || sum_rd)) |=> $stable(irq));
  p_bad_data_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bad_data && !rd_en) |=> $stable(irq));
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> (irq == '0));
endmodule

bind msi_term_bank msi_term_bank_chk #(
  .GROUPS(GROUPS), .IDXS(IDXS), .BITS(BITS), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_msi_term_bank.sv
module tb_msi_term_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 0;
  logic [23:0] rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  msi_term_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [23:0] ia(int g, int x);
    return 24'((g << 19) + (x << 16));
  endfunction
  function automatic logic [23:0] sa(int g);
    return 24'(32'h800000 + (g << 16));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [23:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
    chk("R10", 32'(rd_valid), 1);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R9", 32'(irq), 0);
    chk("R9", 32'(rd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10", 32'(rd_valid), 0);

    // Full sweep of groups, indices and bits
    for (int g = 0; g < 16; g++)
      for (int x = 0; x < 8; x++)
        for (int b = 0; b < 16; b++) begin
          wr(ia(g, x), 32'(b));
          chk("R7", 32'(irq), 32'(1) << g);
          rd(sa(g), v);
          chk("R2", v, 32'(1) << x);
          chk("R8", 32'(irq), 32'(1) << g);
          rd(ia(g, x), v);
          chk("R1", v, 32'(1) << b);
          chk("R3", 32'(irq), 0);
          rd(ia(g, x), v);
          chk("R3", v, 0);
        end

    // Accumulate every bit in one register
    for (int b = 0; b < 16; b++) wr(ia(9, 4), 32'(b));
    rd(ia(9, 4), v);
    chk("R1", v, 32'hFFFF);

    // Summary with several index registers
    wr(ia(5, 0), 2); wr(ia(5, 3), 7); wr(ia(5, 7), 15); wr(ia(2, 1), 0);
    rd(sa(5), v);
    chk("R2", v, 32'h89);
    rd(sa(5), v);
    chk("R8", v, 32'h89);
    chk("R7", 32'(irq), 32'h0024);
    rd(ia(5, 3), v);
    chk("R2", v, 32'h80);
    rd(sa(5), v);
    chk("R2", v, 32'h81);

    // Simultaneous set and clear of one register
    wr(ia(12, 6), 3);
    @(negedge clk);
    wr_en = 1; wr_addr = ia(12, 6); wr_data = 11;
    rd_en = 1; rd_addr = ia(12, 6);
    @(negedge clk);
    wr_en = 0; rd_en = 0; v = rd_data;
    chk("R4", v, 32'h0008);
    chk("R4", 32'(irq[12]), 1);
    rd(ia(12, 6), v);
    chk("R4", v, 32'h0800);

    // Dropped writes
    wr(ia(1, 1), 16);
    wr(ia(1, 1), 32'h100);
    wr(ia(1, 1) | 24'h1, 4);
    wr(ia(1, 1) | 24'h8000, 4);
    wr(sa(1), 4);
    wr(24'h900000, 4);
    chk("R5", 32'(irq[1]), 0);
    rd(ia(1, 1), v);
    chk("R5", v, 0);
    rd(sa(1), v);
    chk("R6", v, 0);
    rd(24'h900000, v);
    chk("R8", v, 0);

    // Reset clears pending state
    wr(ia(7, 2), 5);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R9", 32'(irq), 0);
    rst_n = 1;
    rd(ia(7, 2), v);
    chk("R9", v, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule